// File: doc/BRIEF.md
# Soft-Start and Soft-Stop Reference Sequencer

This block is the digital controller that sits beside one switching converter and walks a 6-bit reference code up when the converter is told to run and back down when it is told to stop. The code drives an external reference DAC. Each step of the code lasts a fixed number of oscillator ticks, so the whole ramp is timed by the converter's own switching clock. The block also gates the power switch. It raises power-good only once the ramp has finished and the output comparator reports regulation. An undervoltage lockout flag overrides everything: it stops switching in the same cycle and clears the reference.

The controller walks five states. OFF is idle with code 0. RAMP_UP adds one code per step. ON holds the full code. RAMP_DOWN removes one code per step. LOCKOUT is held while the supply is too low. The transitions are these:
- OFF→RAMP_UP when enable is high.
- RAMP_UP→ON after the step taken at full code.
- RAMP_UP→RAMP_DOWN when enable falls.
- ON→RAMP_DOWN when enable falls.
- RAMP_DOWN→RAMP_UP when enable rises.
- RAMP_DOWN→OFF after the step taken at code 0.
- Any state→LOCKOUT while lockout is asserted.
- LOCKOUT→OFF when lockout clears.

Two instances can start in sequence by wiring the power-good output of the first to the enable input of the second.

Top module: `ss_sequencer`

## Requirements
- R1: After reset the block is in OFF with reference code 0, switch-enable 0 and power-good 0.
- R2: Leaving OFF needs enable high and lockout low. The move to RAMP_UP happens on the next clock edge, and switch-enable is then 1 with the code still 0.
- R3: A step occurs on a clock edge where osc_tick is 1 and the step's 64th tick is counted. In RAMP_UP each step raises the code by exactly 1. Clock edges without osc_tick never change the code.
- R4: RAMP_UP goes to ON on the step taken at code 63. From a start at code 0, this is 4096 ticks after entering RAMP_UP. The code stays 63.
- R5: Enable going low in ON moves the block to RAMP_DOWN on the next edge. The step counter restarts, and the code then drops by 1 every 64 ticks from its present value.
- R6: In RAMP_DOWN, the step taken at code 0 moves the block to OFF and drops switch-enable. From ON, this is 4096 ticks after entering RAMP_DOWN.
- R7: A change of enable during a ramp reverses the direction from the present code: a fall in RAMP_UP leads to RAMP_DOWN, and a rise in RAMP_DOWN leads to RAMP_UP. The step counter restarts, so the first new step comes 64 ticks later.
- R8: Switch-enable is 1 only in RAMP_UP, ON and RAMP_DOWN. It is forced to 0 in the same cycle that lockout is high.
- R9: Lockout high moves any state to LOCKOUT on the next edge and clears the code to 0. LOCKOUT goes to OFF on the first edge with lockout low.
- R10: Power-good is 1 only in ON, with in_reg high, enable high and lockout low. It drops in the same cycle that enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per converter oscillator period |
| enable | input | 1 | Active-high run request |
| uvlo | input | 1 | Undervoltage lockout flag, high = supply too low |
| in_reg | input | 1 | Output-in-regulation comparator flag |
| ref_code | output | 6 | Reference code for the external DAC |
| sw_en | output | 1 | Power switch enable |
| pgood | output | 1 | Power-good |

## Verification
The bench reverses the ramp in both directions, once at code 1 and once at code 62. A design that restarts from 0 or from full scale, or that keeps the old step phase, shows a wrong code 64 ticks later. It stalls osc_tick mid-ramp to catch a step timer that counts clocks instead of ticks. It raises lockout and drops enable between clock edges, which catches switch-enable or power-good being registered one cycle late. It samples the last cycle of each full ramp and the cycle after it, so a ramp of 63 or 65 steps fails.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_RAMP_UP   = 3'd1,
        ST_ON        = 3'd2,
        ST_RAMP_DOWN = 3'd3,
        ST_LOCKOUT   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
    parameter int TICKS_PER_STEP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic osc_tick,
    output logic step
);
    localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && osc_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign step = run && osc_tick && (cnt_q == LAST);

endmodule

// File: rtl/ss_code_ramp.sv
module ss_code_ramp #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              dec,
    output logic [CODE_W-1:0] code,
    output logic              at_max,
    output logic              at_zero
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (clr) begin
            code_q <= '0;
        end else if (inc && (code_q != CODE_MAX)) begin
            code_q <= code_q + 1'b1;
        end else if (dec && (code_q != '0)) begin
            code_q <= code_q - 1'b1;
        end
    end

    assign code    = code_q;
    assign at_max  = (code_q == CODE_MAX);
    assign at_zero = (code_q == '0);

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       uvlo,
    input  logic       in_reg,
    input  logic       step,
    input  logic       at_max,
    input  logic       at_zero,
    output seq_state_e state,
    output logic       timer_run,
    output logic       timer_clr,
    output logic       code_inc,
    output logic       code_dec,
    output logic       code_clr,
    output logic       sw_en,
    output logic       pgood
);
    seq_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (uvlo) begin
            state_d = ST_LOCKOUT;
        end else begin
            unique case (state_q)
                ST_OFF:       if (enable) state_d = ST_RAMP_UP;
                ST_RAMP_UP: begin
                    if (!enable)              state_d = ST_RAMP_DOWN;
                    else if (step && at_max)  state_d = ST_ON;
                end
                ST_ON:        if (!enable) state_d = ST_RAMP_DOWN;
                ST_RAMP_DOWN: begin
                    if (enable)               state_d = ST_RAMP_UP;
                    else if (step && at_zero) state_d = ST_OFF;
                end
                ST_LOCKOUT:   state_d = ST_OFF;
                default:      state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        timer_run = 1'b0;
        code_inc  = 1'b0;
        code_dec  = 1'b0;
        sw_en     = 1'b0;
        pgood     = 1'b0;
        unique case (state_q)
            ST_OFF: ;
            ST_RAMP_UP: begin
                timer_run = 1'b1;
                sw_en     = 1'b1;
                code_inc  = step && !at_max && (state_d == ST_RAMP_UP);
            end
            ST_ON: begin
                sw_en = 1'b1;
                pgood = in_reg && enable;
            end
            ST_RAMP_DOWN: begin
                timer_run = 1'b1;
                sw_en     = 1'b1;
                code_dec  = step && !at_zero && (state_d == ST_RAMP_DOWN);
            end
            ST_LOCKOUT: ;
            default: ;
        endcase
        if (uvlo) begin
            sw_en = 1'b0;
            pgood = 1'b0;
        end
    end

    assign timer_clr = (state_d != state_q);
    assign code_clr  = uvlo;
    assign state     = state_q;

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
    import ss_pkg::*;
#(
    parameter int CODE_W         = 6,
    parameter int TICKS_PER_STEP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              enable,
    input  logic              uvlo,
    input  logic              in_reg,
    output logic [CODE_W-1:0] ref_code,
    output logic              sw_en,
    output logic              pgood
);
    seq_state_e state;
    logic timer_run, timer_clr, step;
    logic code_inc, code_dec, code_clr, at_max, at_zero;

    ss_step_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .clr      (timer_clr),
        .osc_tick (osc_tick),
        .step     (step)
    );

    ss_code_ramp #(.CODE_W(CODE_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (code_clr),
        .inc     (code_inc),
        .dec     (code_dec),
        .code    (ref_code),
        .at_max  (at_max),
        .at_zero (at_zero)
    );

    ss_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .uvlo      (uvlo),
        .in_reg    (in_reg),
        .step      (step),
        .at_max    (at_max),
        .at_zero   (at_zero),
        .state     (state),
        .timer_run (timer_run),
        .timer_clr (timer_clr),
        .code_inc  (code_inc),
        .code_dec  (code_dec),
        .code_clr  (code_clr),
        .sw_en     (sw_en),
        .pgood     (pgood)
    );

endmodule

// File: rtl/ss_sequencer_chk.sv
module ss_sequencer_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic              enable,
    input logic              uvlo,
    input logic              in_reg,
    input logic [CODE_W-1:0] ref_code,
    input logic              sw_en,
    input logic              pgood
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    a_r9_lockout_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (ref_code == '0));

    a_r8_lockout_stops_switch: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |-> !sw_en);

    a_r10_pgood_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (in_reg && enable && !uvlo && sw_en && ref_code == CODE_MAX));

    a_r3_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !uvlo) |=> $stable(ref_code));

    a_r3_single_code_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ref_code) && !$past(uvlo)) |->
            (ref_code == $past(ref_code) + 1'b1 || ref_code == $past(ref_code) - 1'b1));

    a_r6_switch_off_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sw_en) && !uvlo) |-> (ref_code == '0));

endmodule

bind ss_sequencer ss_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .enable   (enable),
    .uvlo     (uvlo),
    .in_reg   (in_reg),
    .ref_code (ref_code),
    .sw_en    (sw_en),
    .pgood    (pgood)
);

// File: tb/tb_ss_sequencer.sv
`timescale 1ns/1ps
module tb_ss_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b1;
    logic enable = 1'b0;
    logic uvlo = 1'b0;
    logic in_reg = 1'b0;
    logic [5:0] ref_code;
    logic sw_en, pgood;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ss_sequencer dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .enable(enable),
        .uvlo(uvlo), .in_reg(in_reg), .ref_code(ref_code), .sw_en(sw_en), .pgood(pgood)
    );

    // vector: {enable, uvlo, in_reg, cycles[12:0], exp_code[5:0], exp_sw, exp_pg}
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {3'b000, 13'd5,    6'd0,  1'b0, 1'b0},  // R2 idle while disabled
        {3'b110, 13'd10,   6'd0,  1'b0, 1'b0},  // R2 R9 lockout blocks start
        {3'b100, 13'd1,    6'd0,  1'b0, 1'b0},  // R9 LOCKOUT -> OFF
        {3'b100, 13'd1,    6'd0,  1'b1, 1'b0},  // R2 OFF -> RAMP_UP
        {3'b100, 13'd64,   6'd1,  1'b1, 1'b0},  // R3 first step
        {3'b000, 13'd65,   6'd0,  1'b1, 1'b0},  // R7 reverse down from code 1
        {3'b100, 13'd1,    6'd0,  1'b1, 1'b0},  // R7 reverse up
        {3'b101, 13'd4095, 6'd63, 1'b1, 1'b0},  // R4 R10 last ramp cycle, no pgood
        {3'b101, 13'd1,    6'd63, 1'b1, 1'b1},  // R4 R10 ON with pgood
        {3'b100, 13'd1,    6'd63, 1'b1, 1'b0},  // R10 in_reg low
        {3'b001, 13'd1,    6'd63, 1'b1, 1'b0},  // R5 ON -> RAMP_DOWN
        {3'b001, 13'd64,   6'd62, 1'b1, 1'b0},  // R5 first down step
        {3'b101, 13'd1,    6'd62, 1'b1, 1'b0},  // R7 reverse up from 62
        {3'b101, 13'd64,   6'd63, 1'b1, 1'b0},  // R7 restarted step
        {3'b101, 13'd64,   6'd63, 1'b1, 1'b1},  // R4 back in ON
        {3'b000, 13'd129,  6'd61, 1'b1, 1'b0},  // R5 two down steps
        {3'b010, 13'd1,    6'd0,  1'b0, 1'b0},  // R9 lockout clears code
        {3'b000, 13'd2,    6'd0,  1'b0, 1'b0}   // R9 back to OFF
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 code", ref_code, 0);
        chk("R1 sw_en", sw_en, 0);
        chk("R1 pgood", pgood, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            enable = VEC[i][23];
            uvlo   = VEC[i][22];
            in_reg = VEC[i][21];
            run(int'(VEC[i][20:8]));
            chk($sformatf("vec%0d code", i), ref_code, int'(VEC[i][7:2]));
            chk($sformatf("vec%0d sw_en", i), sw_en, int'(VEC[i][1]));
            chk($sformatf("vec%0d pgood", i), pgood, int'(VEC[i][0]));
        end

        // R3 stalled oscillator: no progress
        osc_tick = 1'b0;
        enable = 1'b1;
        run(200);
        chk("R3 stall code", ref_code, 0);
        chk("R2 stall sw_en", sw_en, 1);
        osc_tick = 1'b1;
        run(64);
        chk("R3 step after stall", ref_code, 1);

        // R8 lockout drops switch in same cycle, R9 clears code
        uvlo = 1'b1;
        #1;
        chk("R8 same-cycle sw_en", sw_en, 0);
        run(1);
        chk("R9 code cleared", ref_code, 0);
        uvlo = 1'b0;
        enable = 1'b0;
        run(2);
        chk("R9 OFF after lockout", sw_en, 0);

        // full ramp up then full ramp down
        enable = 1'b1;
        in_reg = 1'b1;
        run(4096);
        chk("R4 before ON pgood", pgood, 0);
        run(1);
        chk("R4 ON pgood", pgood, 1);
        chk("R4 ON code", ref_code, 63);
        enable = 1'b0;
        #1;
        chk("R10 same-cycle pgood drop", pgood, 0);
        run(4096);
        chk("R6 code at end", ref_code, 0);
        chk("R6 sw_en last cycle", sw_en, 1);
        run(1);
        chk("R6 sw_en off", sw_en, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule